// File: doc/BRIEF.md
# Dual-Badline DMA Sequencer

This block plans the bus-stealing schedule of a text-mode video controller whose character rows each need two DMA lines. One line loads the 8-bit character codes and the other loads the 8-bit attributes (colour, luminance, flash). The code line is the last raster line of the row above. The attribute line is the first raster line of the row itself. Both lines therefore hold their data before the row is drawn. The sequencer is clocked once per bus half-cycle. It reads the raster line, the half-cycle position in the line, the vertical fine scroll and a display-enable bit. From these it drives the bus-request and bus-grant strobes, a fetch-kind code for every half-cycle, the idle-read address, and a flag that tells the data path whether the current DMA line is the second of its pair.

Both DMA lines of a pair use the same bus timing. Only the flag differs. The line type is decided at the first half-cycle of each raster line and is held until the next line begins. Every output is registered, so each output shows the half-cycle position that was presented one clock earlier.

Top module: `dbl_dma_sequencer`

## Requirements
- R1: While reset is high and on the first clock after it, ba_n and aec_n are 1, fetch_kind is 00, dummy_addr is 0 and badline_second is 0.
- R2: A raster line L is an attribute line when den is 1, WIN_FIRST <= L <= WIN_LAST, and L mod 8 equals yscroll.
- R3: A raster line L is a code line when line L+1 meets the conditions of R2. As a result, the line just before the first row is a code line, and no code line follows the last row of the window.
- R4: On a code line or an attribute line, ba_n is 0 for the half-cycle positions CHAR_START_HC-12 through CHAR_START_HC+79 (92 half-cycles). It is 1 at every other position. Each output appears one clock after its position is presented.
- R5: On these lines, aec_n is 0 for the positions CHAR_START_HC-6 through CHAR_START_HC+79, and is 1 at every other position.
- R6: The fetch_kind encoding is 00 = bus not taken, 01 = idle read, 10 = code/attribute fetch, 11 = character-ROM fetch. The code is 01 at position CHAR_START_HC-6 and at positions CHAR_START_HC+75 through +79. It is 10 at CHAR_START_HC-5+2k and 11 at CHAR_START_HC-4+2k, for k = 0..39. It is 00 outside the aec_n window.
- R7: dummy_addr is 16'hFFFF while fetch_kind is 01, and 0 otherwise.
- R8: ba_n, aec_n and fetch_kind follow the same half-cycle pattern on a code line as on an attribute line.
- R9: badline_second is 1 on an attribute line from position 0 through CHAR_START_HC+79. It is 0 on every other line and at every other position.
- R10: If yscroll, den or raster_line change after position 0 of a line, the line type does not change until the next position 0.
- R11: On a line that is neither a code line nor an attribute line (including any line with den at 0), ba_n and aec_n stay 1, fetch_kind stays 00 and badline_second stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_line | input | LINE_W (9) | Current raster line |
| hcount | input | HC_W (8) | Half-cycle position within the line, 0 to HALF_CYCLES-1 |
| yscroll | input | SCROLL_W (3) | Vertical fine scroll, the row-phase line number |
| den | input | 1 | Display enable; 0 suppresses all DMA lines |
| ba_n | output | 1 | Bus-available request, active low |
| aec_n | output | 1 | Bus taken by the video fetcher, active low |
| fetch_kind | output | 2 | Kind of access in this half-cycle (encoding in R6) |
| dummy_addr | output | 16 | Address of the idle read, 0 when no idle read |
| badline_second | output | 1 | Current DMA line is the attribute (second) line of its pair |

## Verification
If the latched line type is wrong, the error shows at the ports within the same line. The whole 92-half-cycle ba_n window goes missing or appears where it should not, and badline_second is wrong from the first output of the line. If the slot phase is wrong, the 10/11 alternation shifts by one position. This is seen one clock after the first fetch slot. Errors at the edges of the window show up as a code line after the last row or a missing one before the first row. Errors in the mid-line latch only show when yscroll changes during a line.

// File: rtl/dbl_pkg.sv
`timescale 1ns/1ps
package dbl_pkg;

    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_PTR  = 2'd1,
        LK_ATTR = 2'd2
    } line_kind_e;

    typedef enum logic [1:0] {
        FK_NONE    = 2'b00,
        FK_DUMMY   = 2'b01,
        FK_PTRATTR = 2'b10,
        FK_CROM    = 2'b11
    } fetch_kind_e;

    typedef struct packed {
        logic        ba_n;
        logic        aec_n;
        fetch_kind_e kind;
        logic        dummy;
        logic        second;
    } slot_out_t;

    localparam slot_out_t SLOT_IDLE = '{
        ba_n:   1'b1,
        aec_n:  1'b1,
        kind:   FK_NONE,
        dummy:  1'b0,
        second: 1'b0
    };

    function automatic logic in_span(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/dbl_line_classifier.sv
`timescale 1ns/1ps
module dbl_line_classifier
    import dbl_pkg::*;
#(
    parameter int LINE_W    = 9,
    parameter int SCROLL_W  = 3,
    parameter int WIN_FIRST = 3,
    parameter int WIN_LAST  = 202
) (
    input  logic [LINE_W-1:0]   line,
    input  logic [SCROLL_W-1:0] yscroll,
    input  logic                den,
    output line_kind_e          kind
);
    localparam int EXT_W = LINE_W + 1;

    logic [EXT_W-1:0] cur_x;
    logic [EXT_W-1:0] nxt_x;
    logic             cur_attr;
    logic             nxt_attr;

    assign cur_x = {1'b0, line};
    assign nxt_x = cur_x + EXT_W'(1);

    // A line opens a row when it lies in the window and its phase matches the scroll.
    assign cur_attr = den && in_span(int'(cur_x), WIN_FIRST, WIN_LAST)
                          && (cur_x[SCROLL_W-1:0] == yscroll);
    assign nxt_attr = den && in_span(int'(nxt_x), WIN_FIRST, WIN_LAST)
                          && (nxt_x[SCROLL_W-1:0] == yscroll);

    always_comb begin
        if (cur_attr)      kind = LK_ATTR;
        else if (nxt_attr) kind = LK_PTR;
        else               kind = LK_NONE;
    end
endmodule

// File: rtl/dbl_line_latch.sv
`timescale 1ns/1ps
module dbl_line_latch
    import dbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    input  line_kind_e kind_in,
    output line_kind_e kind_now
);
    line_kind_e kind_q;

    always_ff @(posedge clk) begin
        if (rst)             kind_q <= LK_NONE;
        else if (line_start) kind_q <= kind_in;
    end

    // The new classification takes effect at position 0 itself.
    assign kind_now = line_start ? kind_in : kind_q;
endmodule

// File: rtl/dbl_slot_timer.sv
`timescale 1ns/1ps
module dbl_slot_timer
    import dbl_pkg::*;
#(
    parameter int HC_W          = 8,
    parameter int CHAR_START_HC = 40,
    parameter int NUM_COLS      = 40,
    parameter int BA_LEAD_HC    = 12,
    parameter int AEC_LEAD_HC   = 6
) (
    input  logic [HC_W-1:0] hc,
    input  line_kind_e      kind,
    output slot_out_t       slot
);
    localparam int BA_START    = CHAR_START_HC - BA_LEAD_HC;
    localparam int AEC_START   = CHAR_START_HC - AEC_LEAD_HC;
    localparam int WIN_END     = CHAR_START_HC + 2 * NUM_COLS - 1;
    localparam int FETCH_FIRST = AEC_START + 1;
    localparam int FETCH_LAST  = FETCH_FIRST + 2 * NUM_COLS - 1;
    localparam logic FETCH_PAR = 1'(FETCH_FIRST % 2);

    int   pos;
    logic bad;
    logic in_ba;
    logic in_aec;
    logic in_fetch;
    logic ptr_phase;

    assign pos       = int'(hc);
    assign bad       = (kind != LK_NONE);
    assign in_ba     = in_span(pos, BA_START, WIN_END);
    assign in_aec    = in_span(pos, AEC_START, WIN_END);
    assign in_fetch  = in_span(pos, FETCH_FIRST, FETCH_LAST);
    assign ptr_phase = (hc[0] == FETCH_PAR);

    always_comb begin
        slot        = SLOT_IDLE;
        slot.second = (kind == LK_ATTR) && (pos <= WIN_END);
        if (bad) begin
            slot.ba_n  = !in_ba;
            slot.aec_n = !in_aec;
            if (in_fetch) begin
                slot.kind = ptr_phase ? FK_PTRATTR : FK_CROM;
            end else if (in_aec) begin
                slot.kind  = FK_DUMMY;
                slot.dummy = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbl_dma_sequencer.sv
`timescale 1ns/1ps
module dbl_dma_sequencer
    import dbl_pkg::*;
#(
    parameter int LINES         = 312,
    parameter int HALF_CYCLES   = 228,
    parameter int ROW_LINES     = 8,
    parameter int WIN_FIRST     = 3,
    parameter int WIN_LAST      = 202,
    parameter int CHAR_START_HC = 40,
    parameter int NUM_COLS      = 40,
    parameter int BA_LEAD_HC    = 12,
    parameter int AEC_LEAD_HC   = 6,
    parameter logic [15:0] DUMMY_ADDR = 16'hFFFF,
    localparam int LINE_W   = $clog2(LINES),
    localparam int HC_W     = $clog2(HALF_CYCLES),
    localparam int SCROLL_W = $clog2(ROW_LINES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINE_W-1:0]   raster_line,
    input  logic [HC_W-1:0]     hcount,
    input  logic [SCROLL_W-1:0] yscroll,
    input  logic                den,
    output logic                ba_n,
    output logic                aec_n,
    output logic [1:0]          fetch_kind,
    output logic [15:0]         dummy_addr,
    output logic                badline_second
);
    line_kind_e kind_raw;
    line_kind_e kind_now;
    slot_out_t  slot_nxt;
    slot_out_t  slot_q;

    dbl_line_classifier #(
        .LINE_W   (LINE_W),
        .SCROLL_W (SCROLL_W),
        .WIN_FIRST(WIN_FIRST),
        .WIN_LAST (WIN_LAST)
    ) classify_i (
        .line    (raster_line),
        .yscroll (yscroll),
        .den     (den),
        .kind    (kind_raw)
    );

    dbl_line_latch latch_i (
        .clk        (clk),
        .rst        (rst),
        .line_start (hcount == '0),
        .kind_in    (kind_raw),
        .kind_now   (kind_now)
    );

    dbl_slot_timer #(
        .HC_W          (HC_W),
        .CHAR_START_HC (CHAR_START_HC),
        .NUM_COLS      (NUM_COLS),
        .BA_LEAD_HC    (BA_LEAD_HC),
        .AEC_LEAD_HC   (AEC_LEAD_HC)
    ) timer_i (
        .hc   (hcount),
        .kind (kind_now),
        .slot (slot_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT_IDLE;
        else     slot_q <= slot_nxt;
    end

    assign ba_n           = slot_q.ba_n;
    assign aec_n          = slot_q.aec_n;
    assign fetch_kind     = slot_q.kind;
    assign dummy_addr     = slot_q.dummy ? DUMMY_ADDR : 16'h0000;
    assign badline_second = slot_q.second;
endmodule

// File: rtl/dbl_dma_sequencer_chk.sv
`timescale 1ns/1ps
module dbl_dma_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        ba_n,
    input logic        aec_n,
    input logic [1:0]  fetch_kind,
    input logic [15:0] dummy_addr,
    input logic        badline_second
);
    a_r5_aec_inside_ba: assert property (@(posedge clk) disable iff (rst)
        !aec_n |-> !ba_n);

    a_r6_no_fetch_when_released: assert property (@(posedge clk) disable iff (rst)
        aec_n |-> fetch_kind == 2'b00);

    a_r6_fetch_when_taken: assert property (@(posedge clk) disable iff (rst)
        !aec_n |-> fetch_kind != 2'b00);

    a_r6_ptr_then_rom: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'b10 |=> fetch_kind == 2'b11);

    a_r6_rom_after_ptr: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'b11 |-> $past(fetch_kind) == 2'b10);

    a_r7_dummy_addr_valid: assert property (@(posedge clk) disable iff (rst)
        fetch_kind == 2'b01 |-> dummy_addr == 16'hFFFF);

    a_r7_dummy_addr_quiet: assert property (@(posedge clk) disable iff (rst)
        fetch_kind != 2'b01 |-> dummy_addr == 16'h0000);

    a_r4_release_together: assert property (@(posedge clk) disable iff (rst)
        $rose(ba_n) |-> $rose(aec_n));

    a_r9_second_ends_with_bus: assert property (@(posedge clk) disable iff (rst)
        $fell(badline_second) |-> $rose(aec_n));
endmodule

bind dbl_dma_sequencer dbl_dma_sequencer_chk chk_i (.*);

// File: tb/dbl_dma_sequencer_tb_top.sv
`timescale 1ns/1ps
module dbl_dma_sequencer_tb_top;
    localparam int HC     = 228;
    localparam int S2     = 40;
    localparam int WF     = 3;
    localparam int WL     = 202;
    localparam int BA_LEN = 92;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  raster_line = '0;
    logic [7:0]  hcount = '0;
    logic [2:0]  yscroll = '0;
    logic        den = 1'b1;
    logic        ba_n;
    logic        aec_n;
    logic [1:0]  fetch_kind;
    logic [15:0] dummy_addr;
    logic        badline_second;

    int checks = 0;
    int errors = 0;
    int last_sig = -1;

    always #5 clk = ~clk;

    dbl_dma_sequencer dut_i (
        .clk(clk), .rst(rst), .raster_line(raster_line), .hcount(hcount),
        .yscroll(yscroll), .den(den), .ba_n(ba_n), .aec_n(aec_n),
        .fetch_kind(fetch_kind), .dummy_addr(dummy_addr),
        .badline_second(badline_second)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit is_attr(input int l, input int ys, input bit d);
        return d && l >= WF && l <= WL && (l % 8) == ys;
    endfunction

    // 0 none, 1 code line, 2 attribute line
    function automatic int classify(input int l, input int ys, input bit d);
        if (is_attr(l, ys, d))     return 2;
        if (is_attr(l + 1, ys, d)) return 1;
        return 0;
    endfunction

    task automatic run_line(input int l, input int ys, input bit d,
                            input int ys_mid, input string tag);
        int kind = 0;
        int ba_cnt = 0;
        int sig = 0;
        for (int h = 0; h < HC; h++) begin
            raster_line = 9'(l);
            hcount = 8'(h);
            den = d;
            yscroll = (ys_mid >= 0 && h >= 100) ? 3'(ys_mid) : 3'(ys);
            if (h == 0) kind = classify(l, ys, d);
            @(negedge clk);
            begin
                bit bad = (kind != 0);
                int e_ba = (bad && h >= S2 - 12 && h <= S2 + 79) ? 0 : 1;
                int e_aec = (bad && h >= S2 - 6 && h <= S2 + 79) ? 0 : 1;
                int e_fk = 0;
                int e_sec = (kind == 2 && h <= S2 + 79) ? 1 : 0;
                if (e_aec == 0) begin
                    if (h == S2 - 6 || h >= S2 + 75) e_fk = 1;
                    else if (((h - (S2 - 5)) % 2) == 0) e_fk = 2;
                    else e_fk = 3;
                end
                chk(ba_n == e_ba, "R4", "ba_n", ba_n, e_ba);
                chk(aec_n == e_aec, "R5", "aec_n", aec_n, e_aec);
                chk(fetch_kind == e_fk, "R6", "fetch_kind", fetch_kind, e_fk);
                chk(dummy_addr == ((e_fk == 1) ? 16'hFFFF : 16'h0),
                    "R7", "dummy_addr", dummy_addr, (e_fk == 1) ? 65535 : 0);
                chk(badline_second == e_sec, "R9", "badline_second",
                    badline_second, e_sec);
            end
            if (!ba_n) ba_cnt++;
            sig += (!ba_n ? 7 * h : 0) + (!aec_n ? 13 * h : 0)
                 + int'(fetch_kind) * (h + 1);
        end
        chk(ba_cnt == ((kind != 0) ? BA_LEN : 0), tag, "ba low count",
            ba_cnt, (kind != 0) ? BA_LEN : 0);
        if (kind != 0) begin
            if (last_sig >= 0)
                chk(sig == last_sig, "R8", "pattern signature", sig, last_sig);
            last_sig = sig;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ba_n == 1'b1, "R1", "ba_n in reset", ba_n, 1);
        chk(aec_n == 1'b1, "R1", "aec_n in reset", aec_n, 1);
        chk(fetch_kind == 2'b00, "R1", "fetch_kind in reset", fetch_kind, 0);
        chk(dummy_addr == 16'h0, "R1", "dummy_addr in reset", dummy_addr, 0);
        chk(badline_second == 1'b0, "R1", "second in reset", badline_second, 0);
        rst = 1'b0;

        // R2/R3: window start with scroll 3 (code 2,10,18; attribute 3,11,19)
        for (int l = 0; l < 10; l++)
            run_line(l, 3, 1'b1, -1, (l == 2) ? "R3" : (l == 3) ? "R2" : "R11");
        // R11: display disabled on a line that would otherwise be a code line
        run_line(10, 3, 1'b0, -1, "R11");
        // R10: attribute line with scroll changed mid-line stays attribute
        run_line(11, 3, 1'b1, 5, "R10");
        // R10: plain line whose scroll becomes matching mid-line stays plain
        run_line(12, 3, 1'b1, 4, "R10");
        for (int l = 13; l < 25; l++)
            run_line(l, 3, 1'b1, -1, (l == 18) ? "R3" : (l == 19) ? "R2" : "R11");

        // R2/R3: scroll 0, line 0 lies before the window and is never attribute
        for (int l = 0; l < 13; l++)
            run_line(l, 0, 1'b1, -1, (l == 7) ? "R3" : (l == 8) ? "R2" : "R11");

        // R3: window end with scroll 2 (code 201, attribute 202, no code at 209)
        for (int l = 199; l < 211; l++)
            run_line(l, 2, 1'b1, -1, (l == 201) ? "R3" : (l == 202) ? "R2" : "R11");

        finish_run();
    end
endmodule